// File: doc/BRIEF.md
# Fan-Out Address Register with Bypass

This block takes one 9-bit address and drives four identical copies of it onto four separate 9-bit output groups, for a single address source that feeds four memory banks. A mode input picks where the copies come from. In bypass mode the copies track the input combinationally. In register mode they show the value that an internal edge-triggered register took on at the most recent rising clock edge.

The register loads on every rising clock edge, whatever the mode and output enables are set to. Two active-low enables each control a pair of output groups. A disabled group goes to high impedance. A 4-bit enable vector reports which groups are driving, so a checker can test the driven value and the drive state separately.

Top module: `addr_fanout_reg`

## Requirements
- R1: Every group that is enabled carries the same 9-bit value as every other enabled group.
- R2: While `bypass_sel` is 1, each enabled group equals `a_in` in the same cycle, with no clock edge needed.
- R3: While `bypass_sel` is 0, each enabled group equals the value `a_in` held at the most recent rising edge of `clk` after reset was released.
- R4: The register loads on every rising edge in bypass mode as well. After a switch from bypass to register mode with no edge in between, the groups show the input from the last edge taken in bypass mode.
- R5: `oe_n[0]` low enables groups 0 and 1. `oe_n[0]` high puts both groups into high impedance.
- R6: `oe_n[1]` low enables groups 2 and 3. `oe_n[1]` high puts both groups into high impedance.
- R7: The output enables do not affect the register. Values loaded while both enables are high appear once an enable goes low again.
- R8: While `rst_n` is 0, the register holds zero, so enabled groups read 0 in register mode.
- R9: `grp_en[k]` is 1 exactly when group k drives logic levels, with bit k standing for group k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of the register |
| a_in | input | 9 | Address input |
| bypass_sel | input | 1 | 1 = combinational bypass, 0 = registered |
| oe_n | input | 2 | Active-low enables: bit 0 for groups 0/1, bit 1 for groups 2/3 |
| y_g0 | output | 9 | Output group 0, high impedance when disabled |
| y_g1 | output | 9 | Output group 1, high impedance when disabled |
| y_g2 | output | 9 | Output group 2, high impedance when disabled |
| y_g3 | output | 9 | Output group 3, high impedance when disabled |
| grp_en | output | 4 | Drive state of each group, bit k = group k |

## Verification
The only internal state is the 9-bit register. A wrong value in it shows at the ports on the first cycle that is in register mode with at least one group enabled. It does not show while bypass is selected or both enables are high, so the bench loads data under those conditions and then switches mode or enables to expose it. An enable decode fault shows on `grp_en` in the same cycle as the enable change.

// File: rtl/afr_pkg.sv
package afr_pkg;
  localparam int ADDR_W     = 9;
  localparam int NUM_GRP    = 4;
  localparam int GRP_PER_OE = 2;
  localparam int NUM_OE     = NUM_GRP / GRP_PER_OE;

  typedef enum logic {
    MODE_REG    = 1'b0,
    MODE_BYPASS = 1'b1
  } afr_mode_e;
endpackage

// File: rtl/afr_capture.sv
module afr_capture #(
  parameter int W = afr_pkg::ADDR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         ld_en;

  // loads on every edge, independent of mode and enables
  assign ld_en = 1'b1;

  always_comb begin
    q_nxt = q;
    if (ld_en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/afr_mode_mux.sv
module afr_mode_mux #(
  parameter int W = afr_pkg::ADDR_W
) (
  input  afr_pkg::afr_mode_e mode,
  input  logic [W-1:0]       live,
  input  logic [W-1:0]       held,
  output logic [W-1:0]       sel_val
);
  always_comb begin
    unique case (mode)
      afr_pkg::MODE_BYPASS: sel_val = live;
      default:              sel_val = held;
    endcase
  end
endmodule

// File: rtl/afr_enable_decode.sv
module afr_enable_decode #(
  parameter int NOE = afr_pkg::NUM_OE,
  parameter int GPO = afr_pkg::GRP_PER_OE,
  localparam int NG = NOE * GPO
) (
  input  logic [NOE-1:0] oe_n,
  output logic [NG-1:0]  en
);
  for (genvar o = 0; o < NOE; o++) begin : g_oe
    for (genvar g = 0; g < GPO; g++) begin : g_grp
      assign en[o*GPO + g] = ~oe_n[o];
    end
  end
endmodule

// File: rtl/addr_fanout_reg.sv
module addr_fanout_reg #(
  parameter int W   = afr_pkg::ADDR_W,
  parameter int NOE = afr_pkg::NUM_OE,
  parameter int GPO = afr_pkg::GRP_PER_OE,
  localparam int NG = NOE * GPO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  a_in,
  input  logic          bypass_sel,
  input  logic [NOE-1:0] oe_n,
  output logic [W-1:0]  y_g0,
  output logic [W-1:0]  y_g1,
  output logic [W-1:0]  y_g2,
  output logic [W-1:0]  y_g3,
  output logic [NG-1:0] grp_en
);
  logic [W-1:0]       held_q;
  logic [W-1:0]       drv_val;
  afr_pkg::afr_mode_e mode;

  assign mode = afr_pkg::afr_mode_e'(bypass_sel);

  afr_capture #(.W(W)) u_cap (
    .clk(clk), .rst_n(rst_n), .d(a_in), .q(held_q)
  );

  afr_mode_mux #(.W(W)) u_mux (
    .mode(mode), .live(a_in), .held(held_q), .sel_val(drv_val)
  );

  afr_enable_decode #(.NOE(NOE), .GPO(GPO)) u_dec (
    .oe_n(oe_n), .en(grp_en)
  );

  assign y_g0 = grp_en[0] ? drv_val : {W{1'bz}};
  assign y_g1 = grp_en[1] ? drv_val : {W{1'bz}};
  assign y_g2 = grp_en[2] ? drv_val : {W{1'bz}};
  assign y_g3 = grp_en[3] ? drv_val : {W{1'bz}};

  // R1: enabled groups agree
  p_copies_agree_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_en[0] && grp_en[3]) |-> (y_g0 == y_g3));

  // R2: bypass follows input combinationally
  p_bypass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_sel && grp_en[1]) |-> (y_g1 == a_in));

  // R3: register mode shows input from previous edge
  p_reg_prev_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !bypass_sel && grp_en[2]) |-> (y_g2 == $past(a_in)));

  // R5: high enable turns off the lower pair
  p_oe_pair_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n[0] |-> (!grp_en[0] && !grp_en[1]));

  // R6: low enable turns on the upper pair
  p_oe_pair_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n[1] |-> (grp_en[2] && grp_en[3]));
endmodule

// File: tb/addr_fanout_reg_test.sv
`timescale 1ns/1ps
module addr_fanout_reg_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] a_in;
  logic       bypass_sel;
  logic [1:0] oe_n;
  logic [8:0] y_g0, y_g1, y_g2, y_g3;
  logic [3:0] grp_en;

  int vectors = 0;
  int errors  = 0;
  logic [8:0] ref_q;
  bit done = 0;

  always #10 clk = ~clk;

  addr_fanout_reg uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .bypass_sel(bypass_sel),
    .oe_n(oe_n), .y_g0(y_g0), .y_g1(y_g1), .y_g2(y_g2), .y_g3(y_g3),
    .grp_en(grp_en)
  );

  function automatic logic [8:0] grp_val(input int g);
    case (g)
      0: return y_g0;
      1: return y_g1;
      2: return y_g2;
      default: return y_g3;
    endcase
  endfunction

  task automatic step(input logic [8:0] a, input logic sel,
                      input logic [1:0] oe, input logic rst_v, input string tag);
    logic [8:0] expv;
    logic [3:0] expen;
    @(negedge clk);
    a_in = a; bypass_sel = sel; oe_n = oe; rst_n = rst_v;
    if (!rst_v) ref_q = '0;
    #3;
    expv  = sel ? a : ref_q;
    expen = {{2{~oe[1]}}, {2{~oe[0]}}};
    vectors++;
    if (grp_en !== expen) begin
      errors++;
      $display("FAIL R9/R5/R6 (%s) grp_en=%b expected %b", tag, grp_en, expen);
    end
    for (int g = 0; g < 4; g++) begin
      if (expen[g]) begin
        vectors++;
        if (grp_val(g) !== expv) begin
          errors++;
          $display("FAIL %s group %0d value=%h expected %h", tag, g, grp_val(g), expv);
        end
      end
    end
    @(posedge clk);
    if (rst_n) ref_q = a_in;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; a_in = '0; bypass_sel = 1'b0; oe_n = 2'b00; ref_q = '0;
    // R8: reset holds zero in register mode even with input active
    step(9'h1FF, 1'b0, 2'b00, 1'b0, "R8");
    step(9'h0AA, 1'b0, 2'b00, 1'b0, "R8");
    // R2: bypass follows input, several patterns
    step(9'h155, 1'b1, 2'b00, 1'b1, "R2");
    step(9'h0AA, 1'b1, 2'b00, 1'b1, "R2");
    step(9'h100, 1'b1, 2'b00, 1'b1, "R2");
    // R4: switch to register mode shows last bypass-time capture (0x100)
    step(9'h033, 1'b0, 2'b00, 1'b1, "R4");
    // R3: registered patterns
    step(9'h1C3, 1'b0, 2'b00, 1'b1, "R3");
    step(9'h001, 1'b0, 2'b00, 1'b1, "R3");
    step(9'h1FF, 1'b0, 2'b00, 1'b1, "R3");
    // R5 / R6: individual pair enables
    step(9'h0F0, 1'b0, 2'b01, 1'b1, "R6");
    step(9'h00F, 1'b1, 2'b10, 1'b1, "R5");
    step(9'h123, 1'b0, 2'b10, 1'b1, "R5");
    // R7: load while all disabled, then enable
    step(9'h0C5, 1'b0, 2'b11, 1'b1, "R7");
    step(9'h1A9, 1'b0, 2'b11, 1'b1, "R7");
    step(9'h077, 1'b0, 2'b00, 1'b1, "R7");
    step(9'h077, 1'b0, 2'b01, 1'b1, "R7");
    // R1: mixed random traffic, all enabled groups equal the model
    for (int i = 0; i < 60; i++)
      step(9'($urandom), 1'($urandom), 2'($urandom), 1'b1, "R1");
    // R8 again: mid-run reset
    step(9'h1EE, 1'b0, 2'b00, 1'b0, "R8");
    step(9'h055, 1'b0, 2'b00, 1'b1, "R8");
    step(9'h055, 1'b0, 2'b00, 1'b1, "R3");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule